// File: doc/BRIEF.md
# Load Queue with Race-Free Bypass

This block tracks the in-flight loads of a two-thread core that keeps total store order while letting loads run speculatively out of program order. Each allocated load takes one entry, which holds its thread, its cache-line address, whether it has performed, a compiler-supplied race-free flag, and an age stamp. Two kinds of search look for ordering violations. A coherence probe, raised for an invalidation or an eviction, matches loads of both threads. A store write-back matches only the loads of the other thread. When a search finds a performed, unflagged, uncommitted load on the same line, the block reports a squash for the oldest such load. In the same edge it frees that entry and every younger entry of the same thread.

Loads carrying the race-free flag are invisible to both kinds of search. They also give up their entry on the edge where their completion is signalled, without waiting for in-order commit. This keeps occupancy low, so a smaller queue can stand in for a larger one. A counter records every search whose matching entries were all flagged, which makes the bypass observable. A full indication stalls allocation. Free entries are found with a lowest-index-first pick over the valid bits, because entries leave out of order.

Top module: `lq_rfb`

## Requirements
- R1: After reset no entry is occupied: `full` is 0, `alloc_idx` is 0, `squash_valid` is 0 and `bypass_cnt` is 0.
- R2: When `alloc_valid` is 1 and `full` is 0, the load is written into the lowest-numbered free entry, whose index is shown on `alloc_idx` in the same cycle; the entry becomes occupied at the next rising edge.
- R3: `full` is 1 exactly when all DEPTH entries are occupied; an `alloc_valid` while `full` is 1 is dropped and occupies no entry.
- R4: A load without the race-free flag is marked performed on completion but stays occupied; its entry is freed at the edge where `commit_valid` names its index.
- R5: A load with the race-free flag is freed at the edge where `cmpl_valid` names its index.
- R6: A probe (`probe_valid`) matches occupied entries of either thread whose address bits above bit 5 equal those of `probe_addr` (64-byte lines); a match on a performed, unflagged entry raises `squash_valid` for one cycle after the next rising edge.
- R7: A store search (`st_valid`) matches only entries whose thread differs from `st_tid`, with the same line rule as R6.
- R8: Entries with the race-free flag never cause a squash, and neither do entries that have not performed.
- R9: When several entries qualify for a squash in one cycle, whether from a probe, a store search or both, `squash_idx` and `squash_tid` name the one allocated earliest.
- R10: At the edge that raises a squash, the named entry and every younger entry of the same thread are freed, while older entries of that thread and all entries of the other thread stay occupied.
- R11: `bypass_cnt` increases by one for each search (probe or store) whose set of matching entries is non-empty and made up only of flagged entries, so a probe and a store search in the same cycle can add two; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_tid | input | 1 | Thread of the allocated load |
| alloc_addr | input | ADDR_W | Byte address of the allocated load |
| alloc_rf | input | 1 | Race-free flag of the allocated load |
| alloc_idx | output | IDX_W | Entry that an allocation in this cycle takes |
| full | output | 1 | All entries occupied; allocation stalls |
| cmpl_valid | input | 1 | A load has performed |
| cmpl_idx | input | IDX_W | Entry of the performed load |
| commit_valid | input | 1 | A load commits in order |
| commit_idx | input | IDX_W | Entry of the committing load |
| probe_valid | input | 1 | Invalidation or eviction search |
| probe_addr | input | ADDR_W | Address of the probed line |
| st_valid | input | 1 | Store write-back search |
| st_tid | input | 1 | Thread of the writing store |
| st_addr | input | ADDR_W | Address written by the store |
| squash_valid | output | 1 | Ordering violation found |
| squash_idx | output | IDX_W | Entry of the oldest violating load |
| squash_tid | output | 1 | Thread of the oldest violating load |
| bypass_cnt | output | CNT_W | Searches skipped because all matches were flagged |

## Verification
The bench uses an eight-entry queue and sweeps allocation over every slot, which shows whether the lowest free index is chosen and when the full stall begins. It then probes each line of a queue with alternating flags. It probes once before completion, which separates bypass counting from squashing. It probes again after completion in descending slot order, which shows whether a squash is reported and whether the entries it frees are the ones the younger-same-thread rule names. Store searches from both threads against both threads' loads show whether the other-thread rule holds. A slot reuse that places the younger load at a lower index shows whether age rather than index picks the reported load.

// File: rtl/lq_pkg.sv
package lq_pkg;
    localparam int unsigned LQ_AGE_W = 16;
    typedef logic [LQ_AGE_W-1:0] lq_age_t;

    // Wrap-safe age order: a was allocated before b.
    function automatic logic lq_older(input lq_age_t a, input lq_age_t b);
        lq_age_t diff;
        diff = a - b;
        return diff[LQ_AGE_W-1];
    endfunction
endpackage

// File: rtl/lq_first_free.sv
module lq_first_free #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     vld,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lq_match.sv
module lq_match #(
    parameter int unsigned N      = 8,
    parameter int unsigned LINE_W = 10
) (
    input  logic              en,
    input  logic [LINE_W-1:0] key,
    input  logic              other_only,
    input  logic              key_tid,
    input  logic [N-1:0]      vld,
    input  logic [N-1:0]      rf,
    input  logic [N-1:0]      perf,
    input  logic [N-1:0]      tid,
    input  logic [LINE_W-1:0] line [N],
    output logic [N-1:0]      hit,
    output logic              bypass
);
    logic [N-1:0] cand;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign cand[g] = en && vld[g] && (line[g] == key)
                         && (!other_only || (tid[g] != key_tid));
    end

    assign hit    = cand & ~rf & perf;
    assign bypass = (|cand) && ((cand & ~rf) == '0);
endmodule

// File: rtl/lq_oldest.sv
module lq_oldest
    import lq_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     req,
    input  lq_age_t          age [N],
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    lq_age_t best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || lq_older(age[i], best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = age[i];
            end
        end
    end
endmodule

// File: rtl/lq_rfb.sv
module lq_rfb
    import lq_pkg::*;
#(
    parameter int unsigned DEPTH      = 80,
    parameter int unsigned ADDR_W     = 48,
    parameter int unsigned LINE_BYTES = 64,
    parameter int unsigned CNT_W      = 16,
    localparam int unsigned IDX_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic              alloc_tid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              alloc_rf,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    input  logic              cmpl_valid,
    input  logic [IDX_W-1:0]  cmpl_idx,
    input  logic              commit_valid,
    input  logic [IDX_W-1:0]  commit_idx,
    input  logic              probe_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    input  logic              st_valid,
    input  logic              st_tid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              squash_valid,
    output logic [IDX_W-1:0]  squash_idx,
    output logic              squash_tid,
    output logic [CNT_W-1:0]  bypass_cnt
);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned LINE_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic              vld;
        logic              tid;
        logic [LINE_W-1:0] line;
        logic              perf;
        logic              rf;
        lq_age_t           age;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        lq_age_t          age_ctr;
        logic             sq_vld;
        logic [IDX_W-1:0] sq_idx;
        logic             sq_tid;
        logic [CNT_W-1:0] byp_cnt;
    } st_t;

    st_t s_d, s_q;

    // Flattened views of the entries for the search units.
    logic [DEPTH-1:0]  vld_v, rf_v, perf_v, tid_v;
    logic [LINE_W-1:0] line_v [DEPTH];
    lq_age_t           age_v  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_view
        assign vld_v[g]  = s_q.ent[g].vld;
        assign rf_v[g]   = s_q.ent[g].rf;
        assign perf_v[g] = s_q.ent[g].perf;
        assign tid_v[g]  = s_q.ent[g].tid;
        assign line_v[g] = s_q.ent[g].line;
        assign age_v[g]  = s_q.ent[g].age;
    end

    logic             ff_found;
    logic [IDX_W-1:0] ff_idx;

    lq_first_free #(.N(DEPTH), .IDX_W(IDX_W)) u_free (
        .vld   (vld_v),
        .found (ff_found),
        .idx   (ff_idx)
    );

    // Search unit 0: coherence probe (both threads); unit 1: store (other thread).
    logic [DEPTH-1:0]  hit_s [2];
    logic              byp_s [2];
    logic              srch_en  [2];
    logic [LINE_W-1:0] srch_key [2];

    assign srch_en[0]  = probe_valid;
    assign srch_key[0] = probe_addr[ADDR_W-1:OFF_W];
    assign srch_en[1]  = st_valid;
    assign srch_key[1] = st_addr[ADDR_W-1:OFF_W];

    for (genvar k = 0; k < 2; k++) begin : g_srch
        lq_match #(.N(DEPTH), .LINE_W(LINE_W)) u_match (
            .en         (srch_en[k]),
            .key        (srch_key[k]),
            .other_only (k == 1),
            .key_tid    (st_tid),
            .vld        (vld_v),
            .rf         (rf_v),
            .perf       (perf_v),
            .tid        (tid_v),
            .line       (line_v),
            .hit        (hit_s[k]),
            .bypass     (byp_s[k])
        );
    end

    logic             sq_found;
    logic [IDX_W-1:0] sq_idx;

    lq_oldest #(.N(DEPTH), .IDX_W(IDX_W)) u_oldest (
        .req   (hit_s[0] | hit_s[1]),
        .age   (age_v),
        .found (sq_found),
        .idx   (sq_idx)
    );

    logic unused_offsets;
    assign unused_offsets = ^{alloc_addr[OFF_W-1:0], probe_addr[OFF_W-1:0], st_addr[OFF_W-1:0]};

    logic cmpl_ok, commit_ok, alloc_fire;
    assign cmpl_ok    = cmpl_valid && (32'(cmpl_idx) < DEPTH);
    assign commit_ok  = commit_valid && (32'(commit_idx) < DEPTH);
    assign alloc_fire = alloc_valid && ff_found;

    always_comb begin
        s_d        = s_q;
        s_d.sq_vld = 1'b0;

        if (cmpl_ok && s_q.ent[cmpl_idx].vld) begin
            s_d.ent[cmpl_idx].perf = 1'b1;
            if (s_q.ent[cmpl_idx].rf) begin
                s_d.ent[cmpl_idx].vld = 1'b0;
            end
        end

        if (commit_ok && s_q.ent[commit_idx].vld && !s_q.ent[commit_idx].rf) begin
            s_d.ent[commit_idx].vld = 1'b0;
        end

        if (sq_found) begin
            s_d.sq_vld = 1'b1;
            s_d.sq_idx = sq_idx;
            s_d.sq_tid = s_q.ent[sq_idx].tid;
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.ent[i].vld && (s_q.ent[i].tid == s_q.ent[sq_idx].tid)
                    && !lq_older(s_q.ent[i].age, s_q.ent[sq_idx].age)) begin
                    s_d.ent[i].vld = 1'b0;
                end
            end
        end

        if (alloc_fire) begin
            s_d.ent[ff_idx].vld  = 1'b1;
            s_d.ent[ff_idx].tid  = alloc_tid;
            s_d.ent[ff_idx].line = alloc_addr[ADDR_W-1:OFF_W];
            s_d.ent[ff_idx].perf = 1'b0;
            s_d.ent[ff_idx].rf   = alloc_rf;
            s_d.ent[ff_idx].age  = s_q.age_ctr;
            s_d.age_ctr          = s_q.age_ctr + 1'b1;
        end

        s_d.byp_cnt = s_q.byp_cnt + CNT_W'(byp_s[0]) + CNT_W'(byp_s[1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_idx    = ff_idx;
    assign full         = !ff_found;
    assign squash_valid = s_q.sq_vld;
    assign squash_idx   = s_q.sq_idx;
    assign squash_tid   = s_q.sq_tid;
    assign bypass_cnt   = s_q.byp_cnt;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && alloc_valid && !cmpl_valid && !commit_valid && !sq_found) |=> full); // R3

    AST_RF_EARLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_ok && s_q.ent[cmpl_idx].vld && s_q.ent[cmpl_idx].rf)
        |=> !s_q.ent[$past(cmpl_idx)].vld); // R5

    AST_SQUASH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !s_q.ent[squash_idx].vld); // R10

    AST_SQUASH_FROM_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> $past(probe_valid || st_valid)); // R6

    AST_STORE_OTHER_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid && !$past(probe_valid)) |-> (squash_tid != $past(st_tid))); // R7

    AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(probe_valid || st_valid) |-> $stable(bypass_cnt)); // R11
endmodule

// File: tb/sim_lq_rfb.sv
module sim_lq_rfb;
    localparam int unsigned DEPTH  = 8;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CNT_W  = 16;
    localparam int unsigned IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0, alloc_tid = 1'b0, alloc_rf = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic [IDX_W-1:0]  alloc_idx;
    logic              full;
    logic              cmpl_valid = 1'b0, commit_valid = 1'b0;
    logic [IDX_W-1:0]  cmpl_idx = '0, commit_idx = '0;
    logic              probe_valid = 1'b0, st_valid = 1'b0, st_tid = 1'b0;
    logic [ADDR_W-1:0] probe_addr = '0, st_addr = '0;
    logic              squash_valid, squash_tid;
    logic [IDX_W-1:0]  squash_idx;
    logic [CNT_W-1:0]  bypass_cnt;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lq_rfb #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LINE_BYTES(64), .CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic do_alloc(input logic t, input int a, input logic f);
        alloc_valid = 1'b1; alloc_tid = t; alloc_addr = ADDR_W'(a); alloc_rf = f;
        tick();
        alloc_valid = 1'b0;
    endtask

    task automatic do_cmpl(input int i);
        cmpl_valid = 1'b1; cmpl_idx = IDX_W'(i);
        tick();
        cmpl_valid = 1'b0;
    endtask

    task automatic do_commit(input int i);
        commit_valid = 1'b1; commit_idx = IDX_W'(i);
        tick();
        commit_valid = 1'b0;
    endtask

    task automatic do_probe(input int a);
        probe_valid = 1'b1; probe_addr = ADDR_W'(a);
        tick();
        probe_valid = 1'b0;
    endtask

    task automatic do_store(input logic t, input int a);
        st_valid = 1'b1; st_tid = t; st_addr = ADDR_W'(a);
        tick();
        st_valid = 1'b0;
    endtask

    task automatic chk_sq(input string req, input int v, input int idx, input int t);
        chk(req, int'(squash_valid), v);
        if (v != 0) begin
            chk(req, int'(squash_idx), idx);
            chk(req, int'(squash_tid), t);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 full", int'(full), 0);
        chk("R1 alloc_idx", int'(alloc_idx), 0);
        chk("R1 squash", int'(squash_valid), 0);
        chk("R1 bypass", int'(bypass_cnt), 0);

        // R2, R3: fill sweep, stall, lowest-free refill
        for (int i = 0; i < DEPTH; i++) begin
            chk("R2 alloc_idx", int'(alloc_idx), i);
            chk("R3 not full", int'(full), 0);
            do_alloc(1'(i % 2), i * 64, 1'b0);
        end
        chk("R3 full", int'(full), 1);
        do_alloc(1'b0, 'h1000, 1'b0);
        chk("R3 still full", int'(full), 1);
        do_commit(5);
        chk("R4 commit frees", int'(full), 0);
        chk("R3 dropped alloc", int'(alloc_idx), 5);
        do_commit(2);
        chk("R2 lowest free", int'(alloc_idx), 2);

        // R6, R8, R11, R5, R10: alternating flags, probe sweep
        do_reset();
        for (int i = 0; i < DEPTH; i++) do_alloc(1'b0, i * 64 + (i * 7) % 64, 1'(i % 2));
        for (int i = 0; i < DEPTH; i++) begin
            do_probe(i * 64 + 63);
            chk("R8 unperformed no squash", int'(squash_valid), 0);
            chk("R11 bypass count", int'(bypass_cnt), (i + 1) / 2);
        end
        for (int i = 0; i < DEPTH; i++) do_cmpl(i);
        chk("R5 flagged freed", int'(alloc_idx), 1);
        for (int i = DEPTH - 2; i >= 0; i -= 2) begin
            do_probe(i * 64 + 1);
            chk_sq("R6 probe squash", 1, i, 0);
            do_probe(i * 64 + 1);
            chk("R10 squashed entry gone", int'(squash_valid), 0);
            chk("R11 no match no bypass", int'(bypass_cnt), DEPTH / 2);
        end
        chk("R10 all freed", int'(alloc_idx), 0);

        // R9: age, not index, picks the oldest
        do_reset();
        do_alloc(1'b0, 'h100, 1'b0);   // slot0
        do_alloc(1'b0, 'h200, 1'b0);   // slot1
        do_alloc(1'b1, 'h100, 1'b0);   // slot2
        do_cmpl(0);
        do_commit(0);
        do_alloc(1'b1, 'h120, 1'b0);   // slot0, youngest, same line
        do_cmpl(2);
        do_cmpl(0);
        do_probe('h13f);
        chk_sq("R9 oldest match", 1, 2, 1);
        chk("R10 younger same thread freed", int'(alloc_idx), 0);
        do_probe('h100);
        chk("R10 no survivor on line", int'(squash_valid), 0);
        do_alloc(1'b0, 'h300, 1'b0);
        chk("R10 other thread kept", int'(alloc_idx), 2);

        // R10: older same thread and other thread kept
        do_reset();
        do_alloc(1'b0, 'h040, 1'b0);
        do_alloc(1'b0, 'h080, 1'b0);
        do_alloc(1'b1, 'h0c0, 1'b0);
        do_alloc(1'b0, 'h100, 1'b0);
        do_cmpl(1);
        do_probe('h080);
        chk_sq("R10 squash point", 1, 1, 0);
        chk("R10 freed lowest", int'(alloc_idx), 1);
        do_alloc(1'b0, 'h400, 1'b0);
        chk("R10 younger freed", int'(alloc_idx), 3);
        do_alloc(1'b0, 'h440, 1'b0);
        chk("R10 older kept", int'(alloc_idx), 4);

        // R7, R11: store searches
        do_reset();
        do_alloc(1'b0, 'h200, 1'b0);   // slot0
        do_alloc(1'b1, 'h280, 1'b0);   // slot1
        do_cmpl(0);
        do_cmpl(1);
        do_store(1'b0, 'h210);
        chk("R7 own thread ignored", int'(squash_valid), 0);
        do_store(1'b0, 'h2bf);
        chk_sq("R7 cross thread", 1, 1, 1);
        do_store(1'b1, 'h200);
        chk_sq("R7 cross thread", 1, 0, 0);
        do_alloc(1'b1, 'h500, 1'b1);   // slot0, flagged
        do_store(1'b1, 'h500);
        chk("R11 own thread no bypass", int'(bypass_cnt), 0);
        do_store(1'b0, 'h520);
        chk("R11 store bypass", int'(bypass_cnt), 1);
        probe_valid = 1'b1; probe_addr = 'h53f;
        st_valid = 1'b1; st_tid = 1'b0; st_addr = 'h500;
        tick();
        probe_valid = 1'b0; st_valid = 1'b0;
        chk("R11 double bypass", int'(bypass_cnt), 3);
        chk("R8 flagged no squash", int'(squash_valid), 0);

        // R4, R8: unperformed, performed, committed
        do_reset();
        do_alloc(1'b0, 'h700, 1'b0);
        do_probe('h700);
        chk("R8 unperformed", int'(squash_valid), 0);
        chk("R11 unflagged no bypass", int'(bypass_cnt), 0);
        do_cmpl(0);
        chk("R4 held after completion", int'(alloc_idx), 1);
        do_probe('h710);
        chk_sq("R6 performed hit", 1, 0, 0);
        do_alloc(1'b0, 'h700, 1'b0);
        do_cmpl(0);
        do_commit(0);
        chk("R4 commit frees", int'(alloc_idx), 0);
        do_probe('h700);
        chk("R4 committed not searched", int'(squash_valid), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule